// File: doc/BRIEF.md
# Cascadable Dual Pulse Accumulator

The block counts rising edges on two pulse inputs with a pair of byte-wide counters. Each input first passes through a two-flop synchronizer, and a count is taken on a rising edge of the synchronized level. The low-byte input is the same signal that feeds capture channel 0 elsewhere on the chip. In split mode, each counter has its own enable bit and runs only while that bit is set.

A single mode bit chains the two counters into one 16-bit accumulator. In that mode the low counter counts edges of the low input, and the high counter advances only on the low counter's carry. The individual enables and the high input are then ignored. When the 16-bit value wraps past its maximum, a sticky overflow flag is set. The flag drives an interrupt line through a mask bit. The counters do not depend on any timer enable.

Software uses a small register port. Writes take effect at the clock edge, and the read data is combinational from the address. There are four locations: the mode register, the enable and flag register, the low count byte and the high count byte.

Top module: `pulse_acc_pair`

## Requirements
- R1: After reset, all four locations read 0 and `irq` is low.
- R2: Address 0 is the mode register. Bit 6 is the cascade mode bit and bit 1 is the overflow interrupt mask. Both read back as written, and every other bit reads 0.
- R3: Address 1 holds the split-mode enables: bit 0 for the low counter and bit 1 for the high counter. In split mode (bit 6 of address 0 clear), each counter advances by one per rising edge of its own input only while its enable is 1. The other input has no effect on it.
- R4: A count is taken only on a rising edge of the synchronized input. An input held high for many cycles adds exactly one.
- R5: In cascade mode, the low byte (address 2) counts rising edges of the low input. The high byte (address 3) increments only when the low byte wraps from 0xFF to 0x00, so {address 3, address 2} forms the 16-bit count. The high input has no effect.
- R6: In cascade mode, the enable bits at address 1 have no effect, and counting proceeds with both of them 0.
- R7: In cascade mode, the overflow flag (address 1, bit 7) sets when the 16-bit count wraps from 0xFFFF to 0x0000.
- R8: Writing address 1 with bit 7 = 1 clears the flag, and writing bit 7 = 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly when the flag is set and the interrupt mask (address 0, bit 1) is 1.
- R10: A write to address 2 or address 3 loads that count byte. It takes priority over an increment of the same byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| pulse_lo | input | 1 | Low counter pulse input (shared with capture channel 0) |
| pulse_hi | input | 1 | High counter pulse input |
| irq | output | 1 | Masked overflow interrupt request |

## Verification
The bench sweeps all four enable combinations against several pulse counts on both inputs. A counter that listened to the wrong enable, or to the other channel's input, would show a count that differs from the arithmetic expectation. In cascade mode it preloads values near the byte and word boundaries and steps across them. A design that carried on the wrong condition, or that honoured the split enables there, would land on the wrong 16-bit value or the wrong flag state. Two cases are timed so that a write lands in the exact cycle of the increment: a clear that wrongly beat the wrap would drop the flag, and an increment that beat a load would leave the loaded byte one too high.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENFLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd3;

    localparam int MODE_CASC_BIT = 6;
    localparam int MODE_MASK_BIT = 1;
    localparam int EN_LO_BIT     = 0;
    localparam int EN_HI_BIT     = 1;
    localparam int FLAG_BIT      = 7;

    typedef struct packed {
        logic casc;
        logic ovf_mask;
        logic en_lo;
        logic en_hi;
        logic flag;
    } ctrl_state_t;

endpackage

// File: rtl/pacc_edge_sync.sv
module pacc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    localparam int LAST = STAGES;

    typedef struct packed {
        logic [LAST:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[LAST-1:0], pin};
        rise    = st_q.sh[LAST-1] & ~st_q.sh[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pacc_count_core.sv
module pacc_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         casc,
    input  logic         en_lo,
    input  logic         en_hi,
    input  logic         rise_lo,
    input  logic         rise_hi,
    input  logic         ld_lo,
    input  logic         ld_hi,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic         wrap_full
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic step_lo, step_hi, lo_top;

    always_comb begin
        cnt_d     = cnt_q;
        lo_top    = &cnt_q.lo;
        step_lo   = rise_lo & (casc | en_lo);
        step_hi   = casc ? (step_lo & lo_top) : (rise_hi & en_hi);
        wrap_full = casc & step_lo & lo_top & (&cnt_q.hi);
        if (step_lo) cnt_d.lo = cnt_q.lo + ONE;
        if (step_hi) cnt_d.hi = cnt_q.hi + ONE;
        if (ld_lo)   cnt_d.lo = ld_val;
        if (ld_hi)   cnt_d.hi = ld_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_lo = cnt_q.lo;
    assign cnt_hi = cnt_q.hi;
endmodule

// File: rtl/pacc_ctrl_regs.sv
module pacc_ctrl_regs
    import pacc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              wrap_full,
    input  logic [W-1:0]      cnt_lo,
    input  logic [W-1:0]      cnt_hi,
    output logic              casc,
    output logic              ovf_mask,
    output logic              en_lo,
    output logic              en_hi,
    output logic              flag,
    output logic              ld_lo,
    output logic              ld_hi,
    output logic [W-1:0]      rdata,
    output logic              irq
);
    ctrl_state_t cs_d, cs_q;
    logic [W-1:0] mode_view, enf_view;

    always_comb begin
        cs_d = cs_q;
        if (wr && addr == A_MODE) begin
            cs_d.casc     = wdata[MODE_CASC_BIT];
            cs_d.ovf_mask = wdata[MODE_MASK_BIT];
        end
        if (wr && addr == A_ENFLAG) begin
            cs_d.en_lo = wdata[EN_LO_BIT];
            cs_d.en_hi = wdata[EN_HI_BIT];
            if (wdata[FLAG_BIT]) cs_d.flag = 1'b0;
        end
        if (wrap_full) cs_d.flag = 1'b1;

        ld_lo = wr && addr == A_CNT_LO;
        ld_hi = wr && addr == A_CNT_HI;

        mode_view                = '0;
        mode_view[MODE_CASC_BIT] = cs_q.casc;
        mode_view[MODE_MASK_BIT] = cs_q.ovf_mask;
        enf_view                 = '0;
        enf_view[EN_LO_BIT]      = cs_q.en_lo;
        enf_view[EN_HI_BIT]      = cs_q.en_hi;
        enf_view[FLAG_BIT]       = cs_q.flag;

        unique case (addr)
            A_MODE:   rdata = mode_view;
            A_ENFLAG: rdata = enf_view;
            A_CNT_LO: rdata = cnt_lo;
            default:  rdata = cnt_hi;
        endcase
        irq = cs_q.flag & cs_q.ovf_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign casc     = cs_q.casc;
    assign ovf_mask = cs_q.ovf_mask;
    assign en_lo    = cs_q.en_lo;
    assign en_hi    = cs_q.en_hi;
    assign flag     = cs_q.flag;
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              pulse_lo,
    input  logic              pulse_hi,
    output logic              irq
);
    localparam int NCH = 2;

    logic [NCH-1:0] pins, rises;
    logic casc, ovf_mask, en_lo, en_hi, flag, ld_lo, ld_hi, wrap_full;
    logic [CNT_W-1:0] cnt_lo, cnt_hi;

    assign pins = {pulse_hi, pulse_lo};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
        pacc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[ch]),
            .rise (rises[ch])
        );
    end

    pacc_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .casc     (casc),
        .en_lo    (en_lo),
        .en_hi    (en_hi),
        .rise_lo  (rises[0]),
        .rise_hi  (rises[1]),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .ld_val   (reg_wdata),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi),
        .wrap_full(wrap_full)
    );

    pacc_ctrl_regs #(.W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .wrap_full(wrap_full),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi),
        .casc     (casc),
        .ovf_mask (ovf_mask),
        .en_lo    (en_lo),
        .en_hi    (en_hi),
        .flag     (flag),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .rdata    (reg_rdata),
        .irq      (irq)
    );
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
    import pacc_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wdata,
    input logic              casc,
    input logic              ovf_mask,
    input logic              en_lo,
    input logic              flag,
    input logic              rise_lo,
    input logic [W-1:0]      cnt_lo,
    input logic [W-1:0]      cnt_hi,
    input logic              irq
);
    logic wr_lo, wr_hi, clr_flag;
    assign wr_lo    = wr && addr == A_CNT_LO;
    assign wr_hi    = wr && addr == A_CNT_HI;
    assign clr_flag = wr && addr == A_ENFLAG && wdata[FLAG_BIT];

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_mask |-> !irq);

    a_r7_flag_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(casc) && $past(rise_lo) && (&$past(cnt_lo)) && (&$past(cnt_hi))));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_flag) |=> flag);

    a_r5_hi_only_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && !wr_hi && !(rise_lo && (&cnt_lo))) |=> $stable(cnt_hi));

    a_r6_lo_counts_cascaded: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && rise_lo && !wr_lo) |=> cnt_lo == W'($past(cnt_lo) + W'(1)));

    a_r3_lo_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!casc && !en_lo && !wr_lo) |=> $stable(cnt_lo));

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_lo == $past(wdata));
endmodule

bind pulse_acc_pair pacc_checker #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .casc    (casc),
    .ovf_mask(ovf_mask),
    .en_lo   (en_lo),
    .flag    (flag),
    .rise_lo (rises[0]),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .irq     (irq)
);

// File: tb/pulse_acc_pair_bench.sv
module pulse_acc_pair_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pulse_lo = 1'b0;
    logic       pulse_hi = 1'b0;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pulse_acc_pair u_pulse_acc_pair (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_lo(pulse_lo),
        .pulse_hi(pulse_hi), .irq(irq)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic l, input logic h);
        @(negedge clk);
        pulse_lo = l; pulse_hi = h;
        repeat (2) @(negedge clk);
        pulse_lo = 1'b0; pulse_hi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            summary();
        end
    end

    initial begin
        logic [7:0] d, lo, hi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reset read", d, 0);
        end
        chk("R1 reset irq", irq, 0);

        // R2 mode register bits
        wr(0, 8'hFF); rd(0, d); chk("R2 mode readback ones", d, 8'h42);
        wr(0, 8'h00); rd(0, d); chk("R2 mode readback zero", d, 8'h00);

        // R3 split-mode sweep over enables and pulse counts
        for (int en = 0; en < 4; en++) begin
            wr(1, 8'(en)); wr(2, 0); wr(3, 0);
            for (int p = 1; p <= 4; p++) begin
                pulse(1, 1);
                rd(2, lo); rd(3, hi);
                chk("R3 lo count", lo, en[0] ? p : 0);
                chk("R3 hi count", hi, en[1] ? p : 0);
            end
        end
        wr(1, 8'h03); wr(2, 8'h10); wr(3, 8'h20);
        pulse(1, 0); rd(2, lo); rd(3, hi);
        chk("R3 lo alone lo", lo, 8'h11); chk("R3 lo alone hi", hi, 8'h20);
        pulse(0, 1); rd(2, lo); rd(3, hi);
        chk("R3 hi alone lo", lo, 8'h11); chk("R3 hi alone hi", hi, 8'h21);

        // R4 level held high counts once
        wr(2, 0); wr(3, 0);
        @(negedge clk); pulse_lo = 1; pulse_hi = 1;
        repeat (30) @(negedge clk);
        pulse_lo = 0; pulse_hi = 0;
        repeat (4) @(negedge clk);
        rd(2, lo); rd(3, hi);
        chk("R4 held lo", lo, 1); chk("R4 held hi", hi, 1);

        // R5 R6 R7 cascade sweep over boundary starts, enables at 0
        wr(0, 8'h40);
        for (int s = 0; s < 5; s++) begin
            int start, expv, expf;
            case (s)
                0: start = 16'h0000;
                1: start = 16'h00FE;
                2: start = 16'h12FD;
                3: start = 16'hFEFF;
                default: start = 16'hFFFD;
            endcase
            wr(1, 8'h80);
            wr(2, start[7:0]); wr(3, start[15:8]);
            for (int p = 0; p < 4; p++) pulse(1, 1);
            expv = (start + 4) % 65536;
            expf = (start + 4) > 65535 ? 1 : 0;
            rd(2, lo); rd(3, hi); rd(1, d);
            chk("R5 R6 cascade lo", lo, expv & 8'hFF);
            chk("R5 cascade hi", hi, expv >> 8);
            chk("R7 overflow flag", d[7], expf);
        end
        pulse(0, 1); rd(2, lo); rd(3, hi);
        chk("R5 hi input ignored lo", lo, 8'h01); chk("R5 hi input ignored hi", hi, 8'h00);

        // R9 interrupt gating, flag currently set
        chk("R9 masked irq", irq, 0);
        wr(0, 8'h42); #1 chk("R9 unmasked irq", irq, 1);

        // R8 clear by one, keep on zero
        wr(1, 8'h00); rd(1, d); chk("R8 zero write keeps flag", d[7], 1);
        wr(1, 8'h80); rd(1, d); chk("R8 one write clears flag", d[7], 0);
        chk("R9 irq drops with flag", irq, 0);

        // R8 wrap and clear in the same cycle
        wr(2, 8'hFF); wr(3, 8'hFF);
        @(negedge clk); pulse_lo = 1;
        repeat (2) @(negedge clk);
        reg_wr = 1; reg_addr = 1; reg_wdata = 8'h80;
        @(negedge clk); reg_wr = 0; pulse_lo = 0;
        repeat (3) @(negedge clk);
        rd(1, d); rd(2, lo); rd(3, hi);
        chk("R8 set beats clear", d[7], 1);
        chk("R7 wrapped lo", lo, 0); chk("R7 wrapped hi", hi, 0);
        chk("R9 irq on wrap", irq, 1);

        // R10 load beats increment, split mode
        wr(0, 8'h00); wr(1, 8'h01); wr(2, 8'h05);
        @(negedge clk); pulse_lo = 1;
        repeat (2) @(negedge clk);
        reg_wr = 1; reg_addr = 2; reg_wdata = 8'h33;
        @(negedge clk); reg_wr = 0; pulse_lo = 0;
        repeat (3) @(negedge clk);
        rd(2, lo); chk("R10 load wins", lo, 8'h33);
        pulse(1, 0); rd(2, lo); chk("R10 counts from loaded", lo, 8'h34);

        done = 1;
        summary();
    end
endmodule